// File: doc/BRIEF.md
# Circular-Buffer Post-Increment Address Unit

This unit generates the memory address for a load that walks a circular buffer. It holds a pointer together with three configuration values: a start address, a limit address and a stride. Each time a load fires, the current pointer is presented as the load address. The pointer then moves forward by the stride. If that step reaches or passes the limit, the pointer returns to the start address. A loop that reads a ring of samples therefore needs one load instruction per element. No separate index update, compare or branch is required.

Configuration arrives through a single write port with a two-bit selector. The issued address is registered and comes with a one-cycle valid flag. The data memory and the register writeback sit outside this unit.

Top module: `cbuf_addr_unit`

## Requirements
- R1: After reset `addr_valid` is 0 and `addr_out` is 0. The pointer, start and limit are all 0 and the stride is 1. A load issued before any configuration therefore produces address 0.
- R2: When `ld_fire` is high in a cycle, `addr_out` carries the pointer value from that cycle on the next cycle, and `addr_valid` is 1 on that next cycle. After a cycle with `ld_fire` low, `addr_valid` is 0.
- R3: After a load, the pointer becomes pointer + stride, provided that sum is below the limit.
- R4: If pointer + stride is greater than or equal to the limit, the pointer becomes exactly the start address, and the overshoot is discarded.
- R5: A configuration write with `cfg_sel` = 0 stores the start address and also reloads the pointer to that value.
- R6: A write with `cfg_sel` = 1 stores the limit and a write with `cfg_sel` = 2 stores the stride. Neither changes the pointer. The new value applies from the next load onward.
- R7: When a configuration write and a load happen in the same cycle, the load issues the old pointer and the configuration write takes effect. The load's advance is dropped: the pointer holds, or takes the new start address if the write was to the start register.
- R8: With a stride of 0, repeated loads issue the same address, as long as the pointer is below the limit.
- R9: A configuration write with `cfg_sel` = 3 changes no state.
- R10: If pointer + stride carries out of the address width, the step counts as a wrap and the pointer returns to the start address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Target: 0 start, 1 limit, 2 stride, 3 none |
| cfg_data | input | AW | Configuration value |
| ld_fire | input | 1 | Load issued this cycle |
| addr_out | output | AW | Registered load address |
| addr_valid | output | 1 | `addr_out` holds a fresh address |

## Verification
Two situations are hard to reach from the ports. The first is a configuration write landing in the very cycle a load fires. The bench reaches it with a task that raises `ld_fire` and `cfg_we` together, once with a stride write and once with a start write. The following load then shows whether the advance was dropped. The second is the carry-out wrap. It needs a start address near the top of the address space and a stride whose truncated sum would land below the limit. The bench sets up exactly that pair, so only the carry can trigger the wrap.

// File: rtl/cbuf_pkg.sv
package cbuf_pkg;
  typedef enum logic [1:0] {
    SEL_START  = 2'd0,
    SEL_LIMIT  = 2'd1,
    SEL_STRIDE = 2'd2,
    SEL_NONE   = 2'd3
  } cfg_sel_e;
endpackage

// File: rtl/cbuf_cfg_regs.sv
module cbuf_cfg_regs
  import cbuf_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_sel,
  input  logic [AW-1:0] cfg_data,
  output logic [AW-1:0] start_q,
  output logic [AW-1:0] limit_q,
  output logic [AW-1:0] stride_q,
  output logic          start_wr
);
  localparam logic [AW-1:0] STRIDE_RST = AW'(1);

  cfg_sel_e sel;
  assign sel      = cfg_sel_e'(cfg_sel);
  assign start_wr = cfg_we && (sel == SEL_START);

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q  <= '0;
      limit_q  <= '0;
      stride_q <= STRIDE_RST;
    end else if (cfg_we) begin
      case (sel)
        SEL_START:  start_q  <= cfg_data;
        SEL_LIMIT:  limit_q  <= cfg_data;
        SEL_STRIDE: stride_q <= cfg_data;
        default:    ;
      endcase
    end
  end
endmodule

// File: rtl/cbuf_next_ptr.sv
module cbuf_next_ptr #(
  parameter int AW = 8
) (
  input  logic [AW-1:0] ptr,
  input  logic [AW-1:0] stride,
  input  logic [AW-1:0] start,
  input  logic [AW-1:0] limit,
  output logic [AW-1:0] nxt
);
  localparam int SW = AW + 1;

  logic [SW-1:0] sum;
  logic          wrap;

  always_comb begin
    sum  = {1'b0, ptr} + {1'b0, stride};
    wrap = sum[AW] || (sum[AW-1:0] >= limit);
    nxt  = wrap ? start : sum[AW-1:0];
  end
endmodule

// File: rtl/cbuf_ptr_reg.sv
module cbuf_ptr_reg #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld_fire,
  input  logic          cfg_we,
  input  logic          start_wr,
  input  logic [AW-1:0] cfg_data,
  input  logic [AW-1:0] nxt,
  output logic [AW-1:0] ptr_q,
  output logic [AW-1:0] addr_q,
  output logic          valid_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q   <= '0;
      addr_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= ld_fire;
      if (ld_fire) addr_q <= ptr_q;
      if (start_wr)               ptr_q <= cfg_data;
      else if (ld_fire && !cfg_we) ptr_q <= nxt;
    end
  end
endmodule

// File: rtl/cbuf_addr_unit.sv
module cbuf_addr_unit #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_sel,
  input  logic [AW-1:0] cfg_data,
  input  logic          ld_fire,
  output logic [AW-1:0] addr_out,
  output logic          addr_valid
);
  logic [AW-1:0] start_q, limit_q, stride_q, ptr_q, nxt;
  logic          start_wr;

  cbuf_cfg_regs #(.AW(AW)) cfg_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_data(cfg_data), .start_q(start_q), .limit_q(limit_q),
    .stride_q(stride_q), .start_wr(start_wr)
  );

  cbuf_next_ptr #(.AW(AW)) nxt_i (
    .ptr(ptr_q), .stride(stride_q), .start(start_q), .limit(limit_q),
    .nxt(nxt)
  );

  cbuf_ptr_reg #(.AW(AW)) ptr_i (
    .clk(clk), .rst(rst), .ld_fire(ld_fire), .cfg_we(cfg_we),
    .start_wr(start_wr), .cfg_data(cfg_data), .nxt(nxt),
    .ptr_q(ptr_q), .addr_q(addr_out), .valid_q(addr_valid)
  );
endmodule

// File: rtl/cbuf_addr_unit_chk.sv
module cbuf_addr_unit_chk #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          cfg_we,
  input logic [1:0]    cfg_sel,
  input logic [AW-1:0] cfg_data,
  input logic          ld_fire,
  input logic [AW-1:0] addr_out,
  input logic          addr_valid,
  input logic [AW-1:0] ptr_q,
  input logic [AW-1:0] start_q,
  input logic [AW-1:0] limit_q
);
  AST_VALID_AFTER_FIRE: assert property (@(posedge clk) disable iff (rst)
    ld_fire |=> addr_valid); // R2
  AST_NO_VALID_IDLE: assert property (@(posedge clk) disable iff (rst)
    !ld_fire |=> !addr_valid); // R2
  AST_ADDR_OLD_PTR: assert property (@(posedge clk) disable iff (rst)
    ld_fire |=> addr_out == $past(ptr_q)); // R7
  AST_START_RELOAD: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && cfg_sel == 2'd0) |=> ptr_q == $past(cfg_data)); // R5
  AST_CFG_KEEPS_PTR: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && cfg_sel != 2'd0) |=> $stable(ptr_q)); // R6
  AST_IDLE_KEEPS_PTR: assert property (@(posedge clk) disable iff (rst)
    (!cfg_we && !ld_fire) |=> $stable(ptr_q)); // R9
  AST_STEP_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
    (ld_fire && !cfg_we) |=> (ptr_q < limit_q) || (ptr_q == start_q)); // R4
endmodule

bind cbuf_addr_unit cbuf_addr_unit_chk #(.AW(AW)) chk_i (
  .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
  .cfg_data(cfg_data), .ld_fire(ld_fire), .addr_out(addr_out),
  .addr_valid(addr_valid), .ptr_q(ptr_q), .start_q(start_q),
  .limit_q(limit_q)
);

// File: tb/cbuf_addr_unit_tb_top.sv
`timescale 1ns/1ps
module cbuf_addr_unit_tb_top;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_we = 1'b0;
  logic [1:0]    cfg_sel = '0;
  logic [AW-1:0] cfg_data = '0;
  logic          ld_fire = 1'b0;
  logic [AW-1:0] addr_out;
  logic          addr_valid;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  cbuf_addr_unit #(.AW(AW)) dut_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_data(cfg_data), .ld_fire(ld_fire), .addr_out(addr_out),
    .addr_valid(addr_valid)
  );

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cfg(input logic [1:0] sel, input int val);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_data = AW'(val);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic load(input int exp, input string req);
    @(negedge clk);
    ld_fire = 1'b1;
    @(negedge clk);
    ld_fire = 1'b0;
    check({req, " valid"}, int'(addr_valid), 1);
    check({req, " addr"}, int'(addr_out), exp);
  endtask

  task automatic load_cfg(input logic [1:0] sel, input int val, input int exp, input string req);
    @(negedge clk);
    ld_fire = 1'b1; cfg_we = 1'b1; cfg_sel = sel; cfg_data = AW'(val);
    @(negedge clk);
    ld_fire = 1'b0; cfg_we = 1'b0;
    check({req, " addr"}, int'(addr_out), exp);
  endtask

  task automatic setup(input int s, input int l, input int st);
    cfg(2'd1, l);
    cfg(2'd2, st);
    cfg(2'd0, s);
  endtask

  task automatic t_reset;
    check("R1 valid", int'(addr_valid), 0);
    check("R1 addr", int'(addr_out), 0);
    load(0, "R1");
    load(0, "R1");
  endtask

  task automatic t_walk;
    setup(16, 24, 2);
    load(16, "R3"); load(18, "R3"); load(20, "R3"); load(22, "R3");
    load(16, "R4"); load(18, "R3");
    @(negedge clk);
    check("R2 idle valid", int'(addr_valid), 0);
  endtask

  task automatic t_overshoot;
    setup(40, 50, 3);
    load(40, "R3"); load(43, "R3"); load(46, "R3"); load(49, "R3");
    load(40, "R4");
  endtask

  task automatic t_reload;
    setup(100, 110, 5);
    load(100, "R5"); load(105, "R5");
    cfg(2'd0, 102);
    load(102, "R5"); load(107, "R5"); load(102, "R4");
  endtask

  task automatic t_lim_stride;
    setup(60, 90, 4);
    load(60, "R6");
    cfg(2'd2, 1);
    load(64, "R6"); load(65, "R6");
    cfg(2'd1, 67);
    load(66, "R6"); load(60, "R6");
  endtask

  task automatic t_same_cycle;
    setup(10, 40, 3);
    load(10, "R7");
    load_cfg(2'd2, 5, 13, "R7");
    load(13, "R7"); load(18, "R7");
    load_cfg(2'd0, 30, 23, "R7");
    load(30, "R7"); load(35, "R7");
  endtask

  task automatic t_stride0;
    setup(70, 80, 0);
    load(70, "R8"); load(70, "R8"); load(70, "R8");
  endtask

  task automatic t_sel_none;
    setup(20, 30, 1);
    load(20, "R9");
    cfg(2'd3, 0);
    load(21, "R9"); load(22, "R9");
  endtask

  task automatic t_carry;
    setup(250, 255, 10);
    load(250, "R10"); load(250, "R10");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_walk();
    t_overshoot();
    t_reload();
    t_lim_stride();
    t_same_cycle();
    t_stride0();
    t_sel_none();
    t_carry();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule